// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Condition Flags

This block is the purely combinational datapath unit of a small accumulator processor. Each cycle the decoder hands it an operation code, the accumulator value, a second operand and the current flag byte. In the same cycle it returns the computed byte, a strobe telling the register file whether that byte is to be written to the accumulator, and the next flag byte.

The unit covers the byte arithmetic group: add, add with carry, subtract, subtract with borrow, compare, increment, decrement and negate. It also covers the bitwise group (and, or, exclusive or) and the single-purpose operations that complement the accumulator, invert the carry and set the carry. All arithmetic shares one adder/subtractor. The operand steering in front of it picks the inputs per operation, and a flag composer after it applies the rules for each operation. The unit does not select operands, access memory or do 16-bit arithmetic.

Top module: `alu8_core`

## Requirements
- R1: The flag byte places sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 of flags_out always equal bits 5 and 3 of flags_in.
- R2: For op_sel 0 to 10, the zero flag is 1 exactly when result_out is 0x00, and the sign flag equals bit 7 of result_out.
- R3: Add (op 0) and add-with-carry (op 1) produce acc+opnd, plus the incoming carry for op 1. Carry = carry out of bit 7, half-carry = carry out of bit 3, parity/overflow = signed overflow, subtract flag = 0.
- R4: Subtract (op 2) and subtract-with-borrow (op 3) produce acc-opnd, minus the incoming carry for op 3. Carry = borrow out of bit 7, half-carry = borrow out of bit 3, parity/overflow = signed overflow, subtract flag = 1.
- R5: And (op 4), or (op 5) and xor (op 6) clear carry and the subtract flag. Parity/overflow is 1 when the result has an even count of one bits. Half-carry is 1 for and and 0 for or and xor.
- R6: Compare (op 7) gives the same flag byte that op 2 gives for the same inputs, and wr_en_out is 0.
- R7: Increment (op 8) and decrement (op 9) keep carry. Parity/overflow is set only when acc was 0x7F (op 8) or 0x80 (op 9). The subtract flag is 0 for op 8 and 1 for op 9. Half-carry reports the carry or borrow across bit 3.
- R8: Negate (op 10) yields 0-acc. Parity/overflow is set exactly when acc was 0x80, carry is set exactly when acc was non-zero, the subtract flag is 1, and half-carry is the borrow from bit 3.
- R9: Complement (op 11) yields the bitwise inverse of acc and sets half-carry and the subtract flag. Sign, zero, parity/overflow and carry pass through.
- R10: Carry invert (op 12) inverts carry, puts the old carry into half-carry and clears the subtract flag. Other flags pass through, and wr_en_out is 0.
- R11: Carry set (op 13) sets carry and clears half-carry and the subtract flag. Other flags pass through, and wr_en_out is 0.
- R12: wr_en_out is 1 for op 0 to 6 and op 8 to 11. The unused codes 14 and 15 return acc on result_out with wr_en_out 0 and flags_out equal to flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, values 0 to 13 as listed in the requirements |
| acc_in | input | DATA_W (8) | Accumulator operand |
| opnd_in | input | DATA_W (8) | Second operand |
| flags_in | input | 8 | Current flag byte |
| result_out | output | DATA_W (8) | Computed byte |
| wr_en_out | output | 1 | Result is to be written to the accumulator |
| flags_out | output | 8 | Next flag byte |

## Verification
Several flag conditions can fire on the same vector, and the hard case is carry, overflow and zero together. Adding 0x80 to 0x80 wraps to zero, so it carries out, overflows the signed range and zeroes the byte at once. Subtract-with-borrow of 0x0F from 0x10 with carry set produces a half-borrow and a zero result in one step. These vectors are applied directly, and random vectors add more. A behavioural integer model in the bench works out carry, half-carry and overflow from signed and unsigned sums. Its full flag byte is compared with the unit's output every clock, so a rule that masks or overrides another shows up as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_W = 8;
  localparam int FL_S   = 7;
  localparam int FL_Z   = 6;
  localparam int FL_H   = 4;
  localparam int FL_V   = 2;
  localparam int FL_N   = 1;
  localparam int FL_C   = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_NEG = 4'd10,
    OP_CPL = 4'd11,
    OP_CCF = 4'd12,
    OP_SCF = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              cin_in,
  input  logic              sub_in,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              half_out,
  output logic              ovf_out
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              cin_eff;
  logic [DATA_W:0]   full_sum;
  logic [HALF_W:0]   low_sum;

  // Subtraction is a + ~b + (1 - borrow); carry/borrow outputs are flipped.
  always_comb begin
    b_eff    = sub_in ? ~b_in : b_in;
    cin_eff  = cin_in ^ sub_in;
    full_sum = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
    low_sum  = {1'b0, a_in[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
             + {{HALF_W{1'b0}}, cin_eff};
    sum_out   = full_sum[MSB:0];
    carry_out = full_sum[DATA_W] ^ sub_in;
    half_out  = low_sum[HALF_W] ^ sub_in;
    ovf_out   = (a_in[MSB] == b_eff[MSB]) && (full_sum[MSB] != a_in[MSB]);
  end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic_sel_e        sel_in,
  output logic [DATA_W-1:0] res_out,
  output logic              par_even_out
);

  always_comb begin
    case (sel_in)
      LG_AND:  res_out = a_in & b_in;
      LG_OR:   res_out = a_in | b_in;
      default: res_out = a_in ^ b_in;
    endcase
    par_even_out = ~(^res_out);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result_out,
  output logic              wr_en_out,
  output logic [FLAG_W-1:0] flags_out
);

  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] add_a;
  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic              add_sub;
  logic [DATA_W-1:0] add_sum;
  logic              add_c;
  logic              add_h;
  logic              add_v;
  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] lg_res;
  logic              lg_par;

  assign op = alu_op_e'(op_sel);

  // Operand steering for the shared adder/subtractor.
  always_comb begin
    add_a   = acc_in;
    add_b   = opnd_in;
    add_cin = 1'b0;
    add_sub = 1'b0;
    case (op)
      OP_ADC: add_cin = flags_in[FL_C];
      OP_SUB, OP_CMP: add_sub = 1'b1;
      OP_SBC: begin
        add_sub = 1'b1;
        add_cin = flags_in[FL_C];
      end
      OP_INC: begin
        add_b   = '0;
        add_cin = 1'b1;
      end
      OP_DEC: begin
        add_b   = '0;
        add_cin = 1'b1;
        add_sub = 1'b1;
      end
      OP_NEG: begin
        add_a   = '0;
        add_b   = acc_in;
        add_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
  end

  alu8_addsub #(
    .DATA_W (DATA_W),
    .HALF_W (4)
  ) u_addsub (
    .a_in      (add_a),
    .b_in      (add_b),
    .cin_in    (add_cin),
    .sub_in    (add_sub),
    .sum_out   (add_sum),
    .carry_out (add_c),
    .half_out  (add_h),
    .ovf_out   (add_v)
  );

  alu8_bitwise #(
    .DATA_W (DATA_W)
  ) u_bitwise (
    .a_in         (acc_in),
    .b_in         (opnd_in),
    .sel_in       (lg_sel),
    .res_out      (lg_res),
    .par_even_out (lg_par)
  );

  // Result, write strobe and flag composition per operation.
  always_comb begin
    result_out = acc_in;
    wr_en_out  = 1'b0;
    flags_out  = flags_in;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        result_out      = add_sum;
        wr_en_out       = (op != OP_CMP);
        flags_out[FL_S] = add_sum[MSB];
        flags_out[FL_Z] = (add_sum == '0);
        flags_out[FL_H] = add_h;
        flags_out[FL_V] = add_v;
        flags_out[FL_N] = add_sub;
        flags_out[FL_C] = add_c;
      end
      OP_INC, OP_DEC: begin
        result_out      = add_sum;
        wr_en_out       = 1'b1;
        flags_out[FL_S] = add_sum[MSB];
        flags_out[FL_Z] = (add_sum == '0);
        flags_out[FL_H] = add_h;
        flags_out[FL_V] = add_v;
        flags_out[FL_N] = add_sub;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result_out      = lg_res;
        wr_en_out       = 1'b1;
        flags_out[FL_S] = lg_res[MSB];
        flags_out[FL_Z] = (lg_res == '0);
        flags_out[FL_H] = (op == OP_AND);
        flags_out[FL_V] = lg_par;
        flags_out[FL_N] = 1'b0;
        flags_out[FL_C] = 1'b0;
      end
      OP_CPL: begin
        result_out      = ~acc_in;
        wr_en_out       = 1'b1;
        flags_out[FL_H] = 1'b1;
        flags_out[FL_N] = 1'b1;
      end
      OP_CCF: begin
        flags_out[FL_C] = ~flags_in[FL_C];
        flags_out[FL_H] = flags_in[FL_C];
        flags_out[FL_N] = 1'b0;
      end
      OP_SCF: begin
        flags_out[FL_C] = 1'b1;
        flags_out[FL_H] = 1'b0;
        flags_out[FL_N] = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] opnd_in,
  input logic [FLAG_W-1:0] flags_in,
  input logic [DATA_W-1:0] result_out,
  input logic              wr_en_out,
  input logic [FLAG_W-1:0] flags_out
);

  logic known;
  assign known = !$isunknown({op_sel, acc_in, opnd_in, flags_in});

  always_comb begin
    if (known) begin
      a_r1_spare_bits: assert (flags_out[5] == flags_in[5] && flags_out[3] == flags_in[3]);
      if (op_sel <= 4'd10) begin
        a_r2_zero_flag: assert (flags_out[FL_Z] == (result_out == '0));
      end
      if (op_sel >= 4'd4 && op_sel <= 4'd6) begin
        a_r5_logic_c_n: assert (!flags_out[FL_C] && !flags_out[FL_N]);
      end
      if (op_sel == 4'd7) begin
        a_r6_cmp_no_write: assert (!wr_en_out && flags_out[FL_N]);
      end
      if (op_sel == 4'd8 || op_sel == 4'd9) begin
        a_r7_carry_kept: assert (flags_out[FL_C] == flags_in[FL_C]);
      end
      if (op_sel == 4'd10) begin
        a_r8_neg_carry: assert (flags_out[FL_C] == (acc_in != '0));
      end
      if (op_sel == 4'd12) begin
        a_r10_ccf_swap: assert (flags_out[FL_C] != flags_in[FL_C] && flags_out[FL_H] == flags_in[FL_C]);
      end
      if (op_sel == 4'd13) begin
        a_r11_scf_set: assert (flags_out[FL_C] && !flags_out[FL_H] && !wr_en_out);
      end
      if (op_sel >= 4'd14) begin
        a_r12_unused_hold: assert (!wr_en_out && flags_out == flags_in && result_out == acc_in);
      end
    end
  end

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .op_sel     (op_sel),
  .acc_in     (acc_in),
  .opnd_in    (opnd_in),
  .flags_in   (flags_in),
  .result_out (result_out),
  .wr_en_out  (wr_en_out),
  .flags_out  (flags_out)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] op_sel;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic [7:0] flags_in;
  logic [7:0] result_out;
  logic       wr_en_out;
  logic [7:0] flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  alu8_core u_alu8_core (
    .op_sel     (op_sel),
    .acc_in     (acc_in),
    .opnd_in    (opnd_in),
    .flags_in   (flags_in),
    .result_out (result_out),
    .wr_en_out  (wr_en_out),
    .flags_out  (flags_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int popc(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // Behavioural model: returns {wr_en, result, flags}.
  function automatic logic [16:0] ref_model(input int op, input int a, input int b, input logic [7:0] f);
    logic [7:0] fl = f;
    int r = a;
    logic we = 1'b0;
    int x = 0, y = 0, ci = 0, lo, sx, sy, sr;
    bit sub = 0;
    if (op inside {0, 1, 2, 3, 7, 8, 9, 10}) begin
      case (op)
        0:  begin x = a; y = b; end
        1:  begin x = a; y = b; ci = f[0]; end
        2, 7: begin x = a; y = b; sub = 1; end
        3:  begin x = a; y = b; ci = f[0]; sub = 1; end
        8:  begin x = a; y = 0; ci = 1; end
        9:  begin x = a; y = 0; ci = 1; sub = 1; end
        default: begin x = 0; y = a; sub = 1; end
      endcase
      sx = (x >= 128) ? x - 256 : x;
      sy = (y >= 128) ? y - 256 : y;
      if (sub) begin
        r  = x - y - ci;
        lo = (x % 16) - (y % 16) - ci;
        sr = sx - sy - ci;
        if (op != 8 && op != 9) fl[0] = (r < 0);
        fl[4] = (lo < 0);
      end else begin
        r  = x + y + ci;
        lo = (x % 16) + (y % 16) + ci;
        sr = sx + sy + ci;
        if (op != 8 && op != 9) fl[0] = (r > 255);
        fl[4] = (lo > 15);
      end
      r = r & 255;
      fl[2] = (sr > 127) || (sr < -128);
      fl[1] = sub;
      fl[7] = (r >= 128);
      fl[6] = (r == 0);
      we = (op != 7);
    end else if (op inside {4, 5, 6}) begin
      r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
      fl[7] = (r >= 128);
      fl[6] = (r == 0);
      fl[4] = (op == 4);
      fl[2] = (popc(r) % 2 == 0);
      fl[1] = 1'b0;
      fl[0] = 1'b0;
      we = 1'b1;
    end else if (op == 11) begin
      r = 255 - a;
      fl[4] = 1'b1;
      fl[1] = 1'b1;
      we = 1'b1;
    end else if (op == 12) begin
      fl[4] = f[0];
      fl[0] = !f[0];
      fl[1] = 1'b0;
    end else if (op == 13) begin
      fl[0] = 1'b1;
      fl[4] = 1'b0;
      fl[1] = 1'b0;
    end
    return {we, r[7:0], fl};
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0, 1:   return "R3";
      2, 3:   return "R4";
      4, 5, 6: return "R5";
      7:      return "R6";
      8, 9:   return "R7";
      10:     return "R8";
      11:     return "R9";
      12:     return "R10";
      13:     return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int b, input logic [7:0] f);
    logic [16:0] exp_v;
    logic [16:0] act_v;
    @(posedge clk);
    #2;
    op_sel   = op[3:0];
    acc_in   = a[7:0];
    opnd_in  = b[7:0];
    flags_in = f;
    @(negedge clk);
    exp_v = ref_model(op, a, b, f);
    act_v = {wr_en_out, result_out, flags_out};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: actual %05h expected %05h",
               op_tag(op), op, a, b, f, act_v, exp_v);
    end
    // R1: spare flag bits pass through
    n_checks++;
    if ({flags_out[5], flags_out[3]} !== {f[5], f[3]}) begin
      n_fail++;
      $display("FAIL R1 op=%0d: actual %b expected %b", op, {flags_out[5], flags_out[3]}, {f[5], f[3]});
    end
    // R2: sign and zero track the result
    if (op <= 10) begin
      n_checks++;
      if ({flags_out[7], flags_out[6]} !== {result_out[7], result_out == 8'h00}) begin
        n_fail++;
        $display("FAIL R2 op=%0d: actual %b expected %b", op, {flags_out[7], flags_out[6]},
                 {result_out[7], result_out == 8'h00});
      end
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    op_sel   = '0;
    acc_in   = '0;
    opnd_in  = '0;
    flags_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    apply(0, 8'h7F, 8'h01, 8'h00);  // R3 overflow and half-carry
    apply(0, 8'h80, 8'h80, 8'h00);  // R3 carry, overflow, zero together
    apply(0, 8'hFF, 8'h01, 8'h28);  // R3 wrap, spare bits set
    apply(1, 8'h0F, 8'h00, 8'h01);  // R3 carry-in produces half-carry
    apply(1, 8'hFF, 8'h00, 8'h01);  // R3 carry-in wraps to zero
    apply(2, 8'h00, 8'h01, 8'h00);  // R4 borrow
    apply(2, 8'h80, 8'h01, 8'h00);  // R4 signed overflow
    apply(3, 8'h10, 8'h0F, 8'h01);  // R4 borrow-in, half-borrow, zero
    apply(4, 8'hF0, 8'h0F, 8'h01);  // R5 and to zero, even parity
    apply(5, 8'h01, 8'h02, 8'h11);  // R5 or
    apply(6, 8'h55, 8'hAA, 8'h15);  // R5 xor
    apply(6, 8'h07, 8'h00, 8'h00);  // R5 odd parity
    apply(7, 8'h42, 8'h42, 8'h00);  // R6 equal compare, no write
    apply(7, 8'h10, 8'h20, 8'h00);  // R6 less-than compare
    apply(8, 8'h7F, 8'h00, 8'h01);  // R7 overflow, carry kept set
    apply(8, 8'hFF, 8'h00, 8'h00);  // R7 wrap, carry kept clear
    apply(9, 8'h80, 8'h00, 8'h00);  // R7 overflow on decrement
    apply(9, 8'h00, 8'h00, 8'h01);  // R7 half-borrow, carry kept
    apply(10, 8'h00, 8'h00, 8'h01); // R8 zero negates to zero, no carry
    apply(10, 8'h80, 8'h00, 8'h00); // R8 overflow
    apply(10, 8'h01, 8'h00, 8'h00); // R8 carry, half-borrow
    apply(11, 8'h5A, 8'h00, 8'hC5); // R9 complement
    apply(12, 8'h33, 8'h00, 8'h00); // R10 carry 0 -> 1
    apply(12, 8'h33, 8'h00, 8'hFF); // R10 carry 1 -> 0
    apply(13, 8'h33, 8'h00, 8'h12); // R11 carry set
    apply(14, 8'hA5, 8'h3C, 8'hD7); // R12 unused code
    apply(15, 8'h00, 8'hFF, 8'h28); // R12 unused code

    for (int i = 0; i < 3000; i++) begin
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule